// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Model

This block is a synthesizable behavioural model of a static RAM with separate read and write paths. Each access moves two words. The device's double-edged clocking is folded into one fast system clock. A device cycle takes four system clocks, and each clock stands for one device edge: write-clock rise, inverted write-clock rise, read-clock rise and inverted read-clock rise. The `slot_o` output tells the surrounding logic which edge the next system clock edge represents.

A write request takes one address. It stores the word presented on the write-clock slot at that address, and the word on the next slot at the partner address. Each 9-bit lane of each beat can be masked on its own. A read request takes one address. In the following device cycle it returns the same pair of words on the read-clock slots. If the read clocks are parked high, the pair comes back on the write-clock slots instead. Outside a read burst the data output is not driven, which is shown by `q_drive_o` low and `q_o` at zero.

Top module: `qdrb2_sram`

## Requirements
- R1: After reset `slot_o` is 0. It then steps 0, 1, 2, 3, 0, … on every clock. The codes are 0 = write-clock rise, 1 = inverted write-clock rise, 2 = read-clock rise, 3 = inverted read-clock rise.
- R2: `rd_n_i`, `wr_n_i` and `addr_i` are acted on only at an edge taken while `slot_o` is 0. At slots 1, 2 and 3 they have no effect on memory or output.
- R3: When both `rd_n_i` and `wr_n_i` are high at a slot-0 edge, no word is written and no read burst is started.
- R4: A write with address A stores `d_i` from the slot-0 edge at A, and `d_i` from the following slot-1 edge at the partner address.
- R5: `bw_n_i[0]` low lets bits 8:0 be written and `bw_n_i[1]` low lets bits 17:9 be written. The enables are sampled with each beat's own data. A beat with both enables high leaves the word unchanged.
- R6: With `rclk_parked_i` low at the slot-3 edge that ends the read's device cycle, `q_o` shows the word at A after the slot-2 edge of the next device cycle, and the partner word after that cycle's slot-3 edge. `q_drive_o` is high for both beats.
- R7: With `rclk_parked_i` high at that slot-3 edge, the same two words appear after the slot-0 and slot-1 edges of the next device cycle.
- R8: While and after reset, `q_drive_o` is low and `q_o` is zero until a read burst drives them.
- R9: At the first beat slot of a device cycle that carries no read burst, `q_drive_o` falls and `q_o` returns to zero. Back-to-back bursts keep the output driven.
- R10: A read and a write accepted at the same slot-0 edge are both carried out. The read returns the contents from before the write.
- R11: The partner address is A with its least significant bit inverted, so a burst that starts at an odd address returns A, then A−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four per device cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n_i | input | 1 | Active-low read request |
| wr_n_i | input | 1 | Active-low write request |
| addr_i | input | AW (4) | Shared burst start address |
| d_i | input | 18 | Write data, one word per write beat |
| bw_n_i | input | 2 | Active-low per-lane write enables |
| rclk_parked_i | input | 1 | High when both read clocks are held high |
| q_o | output | 18 | Read data, zero when not driven |
| q_drive_o | output | 1 | High while read data is driven |
| slot_o | output | 2 | Device edge the next clock represents |

## Verification
A wrong phase count skews every later transfer, so the first read beat after the error shows the wrong word, or shows it one slot early or late. A corrupted write-beat address or lane mask stays hidden in the array until that address is read. It then appears as a wrong word seven system clocks after the read is issued. A stale read-pipeline stage shows up within one device cycle, either as a drive that never falls or as data repeated from the previous burst. The bench therefore reads back after every kind of write, and it compares every output on every clock against a reference model.

// File: rtl/qdrb2_pkg.sv
package qdrb2_pkg;

    // One device edge per system clock, in device order
    typedef enum logic [1:0] {
        SLOT_KR  = 2'd0,   // write-clock rise
        SLOT_KNR = 2'd1,   // inverted write-clock rise
        SLOT_CR  = 2'd2,   // read-clock rise
        SLOT_CNR = 2'd3    // inverted read-clock rise
    } slot_e;

endpackage

// File: rtl/qdrb2_slot_seq.sv
module qdrb2_slot_seq
    import qdrb2_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot_o
);

    slot_e slot_d, slot_q;

    always_comb begin
        slot_d = slot_e'(slot_q + 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_KR;
        else        slot_q <= slot_d;
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/qdrb2_array.sv
module qdrb2_array #(
    parameter int AW     = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANE_W*LANES-1:0] wdata,
    input  logic [LANES-1:0]        wlane,
    input  logic [AW-1:0]           raddr,
    output logic [LANE_W*LANES-1:0] rword0,
    output logic [LANE_W*LANES-1:0] rword1
);

    localparam int W     = LANE_W * LANES;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
    } arr_t;

    arr_t st_d, st_q;
    logic [W-1:0] lane_bits;

    // Expand the per-lane enables into a per-bit mask
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_bits[l*LANE_W +: LANE_W] = {LANE_W{wlane[l]}};
    end

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mem[waddr] = (st_q.mem[waddr] & ~lane_bits) | (wdata & lane_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Partner word: least significant address bit inverted
    assign rword0 = st_q.mem[raddr];
    assign rword1 = st_q.mem[raddr ^ AW'(1)];

endmodule

// File: rtl/qdrb2_read_path.sv
module qdrb2_read_path
    import qdrb2_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  slot_e        slot,
    input  logic         capture,
    input  logic [W-1:0] cap_w0,
    input  logic [W-1:0] cap_w1,
    input  logic         parked,
    output logic [W-1:0] q_o,
    output logic         q_drive_o
);

    typedef struct packed {
        logic         cap_vld;
        logic [W-1:0] cap_w0;
        logic [W-1:0] cap_w1;
        logic         out_vld;
        logic         out_park;
        logic [W-1:0] out_w0;
        logic [W-1:0] out_w1;
        logic [W-1:0] q;
        logic         drv;
    } rp_t;

    rp_t   st_d, st_q;
    slot_e beat0, beat1;

    always_comb begin
        st_d  = st_q;
        beat0 = st_q.out_park ? SLOT_KR  : SLOT_CR;
        beat1 = st_q.out_park ? SLOT_KNR : SLOT_CNR;

        // Drive the burst handed over at the end of the previous cycle
        if (slot == beat0) begin
            st_d.drv = st_q.out_vld;
            st_d.q   = st_q.out_vld ? st_q.out_w0 : '0;
        end else if (slot == beat1 && st_q.out_vld) begin
            st_d.q   = st_q.out_w1;
        end

        // Snapshot both words before any write at this edge lands
        if (slot == SLOT_KR) begin
            st_d.cap_vld = capture;
            if (capture) begin
                st_d.cap_w0 = cap_w0;
                st_d.cap_w1 = cap_w1;
            end
        end

        // Hand over to the delivery stage at the end of the device cycle
        if (slot == SLOT_CNR) begin
            st_d.out_vld  = st_q.cap_vld;
            st_d.out_w0   = st_q.cap_w0;
            st_d.out_w1   = st_q.cap_w1;
            st_d.out_park = parked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o       = st_q.q;
    assign q_drive_o = st_q.drv;

endmodule

// File: rtl/qdrb2_sram.sv
module qdrb2_sram
    import qdrb2_pkg::*;
#(
    parameter int AW     = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_n_i,
    input  logic                    wr_n_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [LANE_W*LANES-1:0] d_i,
    input  logic [LANES-1:0]        bw_n_i,
    input  logic                    rclk_parked_i,
    output logic [LANE_W*LANES-1:0] q_o,
    output logic                    q_drive_o,
    output logic [1:0]              slot_o
);

    localparam int W = LANE_W * LANES;

    typedef struct packed {
        logic          wr_act;
        logic [AW-1:0] wr_addr;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    slot_e         slot;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [W-1:0]  rword0, rword1;
    logic          rd_take;

    qdrb2_slot_seq u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot)
    );

    always_comb begin
        ctl_d     = ctl_q;
        arr_we    = 1'b0;
        arr_waddr = addr_i;
        rd_take   = 1'b0;
        unique case (slot)
            SLOT_KR: begin
                rd_take       = !rd_n_i;
                arr_we        = !wr_n_i;
                arr_waddr     = addr_i;
                ctl_d.wr_act  = !wr_n_i;
                ctl_d.wr_addr = addr_i;
            end
            SLOT_KNR: begin
                arr_we       = ctl_q.wr_act;
                arr_waddr    = ctl_q.wr_addr ^ AW'(1);
                ctl_d.wr_act = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    qdrb2_array #(
        .AW     (AW),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (arr_we),
        .waddr  (arr_waddr),
        .wdata  (d_i),
        .wlane  (~bw_n_i),
        .raddr  (addr_i),
        .rword0 (rword0),
        .rword1 (rword1)
    );

    qdrb2_read_path #(
        .W (W)
    ) u_rpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .capture   (rd_take),
        .cap_w0    (rword0),
        .cap_w1    (rword1),
        .parked    (rclk_parked_i),
        .q_o       (q_o),
        .q_drive_o (q_drive_o)
    );

    assign slot_o = slot;

endmodule

// File: rtl/qdrb2_checker.sv
module qdrb2_checker #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   slot,
    input logic         rd_n,
    input logic         wr_n,
    input logic         arr_we,
    input logic [W-1:0] q,
    input logic         q_drive
);

    logic       armed;
    logic [3:0] since_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            since_rd <= 4'd15;
        end else begin
            armed <= 1'b1;
            if (slot == 2'd0 && !rd_n)  since_rd <= 4'd0;
            else if (since_rd != 4'd15) since_rd <= since_rd + 4'd1;
        end
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (slot == $past(slot) + 2'd1)); // R1

    AST_WRITE_IN_K_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (slot == 2'd0 || slot == 2'd1)); // R4

    AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 2'd0 && wr_n) |-> !arr_we); // R3

    AST_ZERO_WHEN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !q_drive |-> (q == '0)); // R9

    AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_drive) |-> (since_rd <= 4'd7)); // R6

endmodule

bind qdrb2_sram qdrb2_checker #(.W(LANE_W*LANES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot    (slot_o),
    .rd_n    (rd_n_i),
    .wr_n    (wr_n_i),
    .arr_we  (arr_we),
    .q       (q_o),
    .q_drive (q_drive_o)
);

// File: tb/test_qdrb2_sram.sv
`timescale 1ns/1ps
module test_qdrb2_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_n = 1'b1, wr_n = 1'b1, park = 1'b0;
    logic [3:0]  addr = '0;
    logic [17:0] d = '0;
    logic [1:0]  bw_n = 2'b11;
    logic [17:0] q_o;
    logic        q_drive_o;
    logic [1:0]  slot_o;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    qdrb2_sram i_qdrb2_sram (
        .clk(clk), .rst_n(rst_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .addr_i(addr),
        .d_i(d), .bw_n_i(bw_n), .rclk_parked_i(park),
        .q_o(q_o), .q_drive_o(q_drive_o), .slot_o(slot_o)
    );

    // ---------------- reference model ----------------
    typedef struct { bit v; logic [17:0] w0; logic [17:0] w1; } burst_t;
    logic [17:0] m_mem [16];
    burst_t      capq[$];
    burst_t      dl;
    bit          dl_park, wp;
    int          p;
    logic [3:0]  wa;
    logic [17:0] m_q;
    bit          m_drv;

    task automatic m_write(input logic [3:0] a, input logic [17:0] w, input logic [1:0] b);
        for (int l = 0; l < 2; l++)
            if (!b[l]) m_mem[a][l*9 +: 9] = w[l*9 +: 9];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = '0;
            capq.delete();
            dl = '{0, 0, 0}; dl_park = 0; wp = 0; p = 0; wa = 0;
            m_q = 0; m_drv = 0;
        end else begin
            int b0, b1;
            b0 = dl_park ? 0 : 2;
            b1 = dl_park ? 1 : 3;
            if (p == b0) begin
                m_drv = dl.v;
                m_q   = dl.v ? dl.w0 : 18'd0;
            end else if (p == b1 && dl.v) begin
                m_q = dl.w1;
            end
            if (p == 0) begin
                burst_t e;
                e.v = !rd_n; e.w0 = m_mem[addr]; e.w1 = m_mem[addr ^ 4'd1];
                capq.push_back(e);
                wp = !wr_n;
                if (!wr_n) begin m_write(addr, d, bw_n); wa = addr; end
            end else if (p == 1 && wp) begin
                m_write(wa ^ 4'd1, d, bw_n);
                wp = 0;
            end
            if (p == 3) begin
                dl = capq.pop_front();
                dl_park = park;
            end
            p = (p + 1) % 4;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(slot_o == 2'(p), "R1", "slot", 18'(slot_o), 18'(p));
        chk(q_drive_o == m_drv, cur_req, "drive", 18'(q_drive_o), 18'(m_drv));
        chk(q_o == m_q, cur_req, "data", q_o, m_q);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    // One device cycle; entered and left at a negedge with slot 0 next
    task automatic dev_cycle(input bit rd, input bit wr, input logic [3:0] a,
                             input logic [17:0] d0, input logic [1:0] b0,
                             input logic [17:0] d1, input logic [1:0] b1,
                             input bit pk, input bit junk);
        rd_n = !rd; wr_n = !wr; addr = a; d = d0; bw_n = b0; park = pk;
        tick();
        d = d1; bw_n = b1;
        rd_n = junk ? 1'b0 : 1'b1; wr_n = junk ? 1'b0 : 1'b1;
        addr = junk ? ~a : a;
        tick();
        d = junk ? 18'h3FFFF : 18'd0; bw_n = junk ? 2'b00 : 2'b11;
        tick();
        tick();
        rd_n = 1'b1; wr_n = 1'b1; bw_n = 2'b11;
    endtask

    // Read A (optionally with a same-cycle write), then check both beats
    task automatic read_expect(input logic [3:0] a, input bit pk, input bit wr,
                               input logic [17:0] wd0, input logic [17:0] wd1,
                               input logic [17:0] e0, input logic [17:0] e1,
                               input string req);
        dev_cycle(1, wr, a, wd0, 2'b00, wd1, 2'b00, pk, 0);
        if (pk) begin
            tick(); chk(q_drive_o && q_o == e0, req, "beat0", q_o, e0);
            tick(); chk(q_drive_o && q_o == e1, req, "beat1", q_o, e1);
            tick(); tick();
        end else begin
            tick(); tick();
            tick(); chk(q_drive_o && q_o == e0, req, "beat0", q_o, e0);
            tick(); chk(q_drive_o && q_o == e1, req, "beat1", q_o, e1);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R8: outputs idle during reset
        chk(q_drive_o == 1'b0 && q_o == 18'd0, "R8", "reset out", q_o, 18'd0);
        chk(slot_o == 2'd0, "R1", "reset slot", 18'(slot_o), 18'd0);
        rst_n = 1'b1;

        // R4 / R6: full write then read back
        cur_req = "R4";
        dev_cycle(0, 1, 4'd4, 18'h2A5A5, 2'b00, 18'h15A5A, 2'b00, 0, 0);
        cur_req = "R6";
        read_expect(4'd4, 0, 0, 0, 0, 18'h2A5A5, 18'h15A5A, "R6");
        // R9: next cycle without a read releases the output
        cur_req = "R9";
        tick(); tick(); tick();
        chk(q_drive_o == 1'b0 && q_o == 18'd0, "R9", "release", q_o, 18'd0);
        tick();
        // R11: odd start address wraps to the even partner
        cur_req = "R11";
        read_expect(4'd5, 0, 0, 0, 0, 18'h15A5A, 18'h2A5A5, "R11");
        // R5: per-beat lane enables
        cur_req = "R5";
        dev_cycle(0, 1, 4'd4, 18'h3FFFF, 2'b10, 18'h00000, 2'b01, 0, 0);
        read_expect(4'd4, 0, 0, 0, 0, 18'h2A5FF, 18'h0005A, "R5");
        // R5: both enables high on both beats leaves the words alone
        dev_cycle(0, 1, 4'd4, 18'h00000, 2'b11, 18'h00000, 2'b11, 0, 0);
        read_expect(4'd4, 0, 0, 0, 0, 18'h2A5FF, 18'h0005A, "R5");
        // R2 / R3: NOP slot-0 with requests toggled only at other slots
        cur_req = "R2";
        dev_cycle(0, 0, 4'd4, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00, 0, 1);
        chk(q_drive_o == 1'b0, "R3", "no burst", 18'(q_drive_o), 18'd0);
        dev_cycle(0, 0, 4'd4, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00, 0, 0);
        chk(q_drive_o == 1'b0, "R2", "ignored req", 18'(q_drive_o), 18'd0);
        read_expect(4'd4, 0, 0, 0, 0, 18'h2A5FF, 18'h0005A, "R3");
        // R10: same-cycle read and write returns old data, then the new
        cur_req = "R10";
        read_expect(4'd4, 0, 1, 18'h11111, 18'h22222, 18'h2A5FF, 18'h0005A, "R10");
        read_expect(4'd4, 0, 0, 0, 0, 18'h11111, 18'h22222, "R10");
        // R7: parked read clocks move delivery to the write-clock slots
        cur_req = "R7";
        read_expect(4'd5, 1, 0, 0, 0, 18'h22222, 18'h11111, "R7");
        park = 1'b0;
        // R9: back-to-back reads keep the output driven
        cur_req = "R9";
        dev_cycle(1, 0, 4'd2, 0, 2'b11, 0, 2'b11, 0, 0);
        dev_cycle(1, 0, 4'd4, 0, 2'b11, 0, 2'b11, 0, 0);
        tick(); tick(); tick();
        chk(q_drive_o == 1'b1, "R9", "held drive", 18'(q_drive_o), 18'd1);
        tick();
        // Mixed traffic against the model
        cur_req = "R6";
        for (int c = 0; c < 400; c++) begin
            bit pk;
            pk = c[4] ^ c[2];
            for (int s = 0; s < 4; s++) begin
                rd_n = 1'($urandom); wr_n = 1'($urandom);
                addr = 4'($urandom); d = 18'($urandom);
                bw_n = 2'($urandom); park = pk;
                tick();
            end
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule